// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry

This block sits beside a simple in-order CPU and decides, at each instruction boundary, whether one of the pending interrupt requests is to be taken. The requests come from four kinds of source: a debug-port interrupt command, an external level pin, a second external pin, and a set of on-chip peripheral lines. Each of the last three carries a priority level and an event code. The debug command always has level 15 and a fixed code.

When a request is accepted, the block captures the return PC and the current status word into save registers and writes the source's event code into two event-code registers. It also produces the new status word, with the block, mode and bank flags set, and drives a one-cycle redirect strobe with the branch target. The pipeline uses the strobe to load the PC and the new status word. All request, control and status pins are plain level signals. There is no streamed data here, so there is no valid/ready handshake and no back-pressure: the pipeline must act on the strobe in the cycle it appears.

Top module: `irq_entry`

## Requirements
- R1: While status bit 28 (block flag) of `sr_in` is 1, no request is accepted and `take` stays 0.
- R2: A request is eligible only if its level is strictly greater than the mask field `sr_in[7:4]`. A request whose level is equal to or below the mask at the boundary is not taken, even if it was above the mask earlier.
- R3: Acceptance is evaluated only in a cycle with `boundary` = 1. `take` is 1 for exactly the cycle after such a cycle and is 0 otherwise.
- R4: On acceptance, `spc` receives the `pc_next` value present in the boundary cycle.
- R5: On acceptance, `ssr` receives the `sr_in` value present in the boundary cycle.
- R6: On acceptance, `evt_a` and `evt_b` both receive the 12-bit event code of the winning source.
- R7: On acceptance, `sr_out` equals the boundary-cycle `sr_in` with bits 28, 29 and 30 forced to 1. All other bits are unchanged, so the mask field keeps its old value and does not take the accepted level.
- R8: While `take` = 1, `target` equals the boundary-cycle `vbr` plus 0x600, for every source.
- R9: The debug command (`dbg_req`) has level 15 and event code 0x5E0. It is taken when the mask is 14 or less and refused when the mask is 15.
- R10: Among eligible requests, the highest level wins. On equal levels the order is: debug, then the external pin, then the second pin, then peripherals from index 0 upward.
- R11: `spc`, `ssr`, `evt_a`, `evt_b` and `sr_out` change only on an acceptance and hold their values otherwise. All are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction-boundary strobe |
| sr_in | input | 32 | Current status register |
| pc_next | input | 32 | PC of the instruction after the current one |
| vbr | input | 32 | Vector base register |
| dbg_req | input | 1 | Debug-port interrupt command |
| ext_req | input | 1 | External level pin request |
| ext_lvl | input | 4 | External pin priority level |
| ext_code | input | 12 | External pin event code |
| aux_req | input | 1 | Second external pin request |
| aux_lvl | input | 4 | Second pin priority level |
| aux_code | input | 12 | Second pin event code |
| per_req | input | NUM_PERIPH | Peripheral request lines |
| per_lvl | input | 4*NUM_PERIPH | Peripheral levels, index i at bits [4i+3:4i] |
| per_code | input | 12*NUM_PERIPH | Peripheral codes, index i at bits [12i+11:12i] |
| take | output | 1 | One-cycle redirect strobe |
| target | output | 32 | Branch target, valid with `take` |
| spc | output | 32 | Saved return PC |
| ssr | output | 32 | Saved status register |
| evt_a | output | 12 | First event-code register |
| evt_b | output | 12 | Second event-code register |
| sr_out | output | 32 | Status word to load on entry |

## Verification
The assertions compare the registered results with `$past` of the inputs. They therefore assume that `sr_in`, `pc_next` and `vbr` are settled in the boundary cycle, and that an event code of 0x5E0 reaches the outputs only from the debug command. The bench assigns the other sources codes that never equal 0x5E0. It changes all inputs only just after a rising edge, so every input is stable across the edge that samples it. The bench also never asserts `boundary` in the cycle right after an acceptance without first updating `sr_in`, which is the pipeline's job outside this block.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 4;
  localparam int CODE_W  = 12;
  localparam int WORD_W  = 32;
  localparam int SR_BL   = 28;
  localparam int SR_RB   = 29;
  localparam int SR_MD   = 30;
  localparam int MASK_LO = 4;
  localparam logic [LVL_W-1:0]  DBG_LVL  = '1;
  localparam logic [CODE_W-1:0] DBG_CODE = 12'h5E0;
  localparam logic [WORD_W-1:0] VEC_OFS  = 32'h0000_0600;

  typedef struct packed {
    logic              vld;
    logic [LVL_W-1:0]  lvl;
    logic [CODE_W-1:0] code;
  } irq_cand_t;

  function automatic logic [WORD_W-1:0] entry_sr(input logic [WORD_W-1:0] sr);
    logic [WORD_W-1:0] r;
    r = sr;
    r[SR_BL] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_MD] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible
  import irq_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  irq_cand_t        raw  [NSRC],
  input  logic [LVL_W-1:0] mask,
  input  logic             blocked,
  output irq_cand_t        elig [NSRC]
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      elig[g]     = raw[g];
      elig[g].vld = raw[g].vld && !blocked && (raw[g].lvl > mask);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  irq_cand_t elig [NSRC],
  output irq_cand_t win
);
  // Strictly-greater compare keeps the lowest index on a tie.
  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i].vld && (!win.vld || (elig[i].lvl > win.lvl))) win = elig[i];
    end
  end
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  input  logic [WORD_W-1:0] sr_in,
  input  logic [WORD_W-1:0] pc_next,
  input  logic [WORD_W-1:0] vbr,
  output logic              take,
  output logic [WORD_W-1:0] target,
  output logic [WORD_W-1:0] spc,
  output logic [WORD_W-1:0] ssr,
  output logic [CODE_W-1:0] evt_a,
  output logic [CODE_W-1:0] evt_b,
  output logic [WORD_W-1:0] sr_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take   <= 1'b0;
      target <= '0;
      spc    <= '0;
      ssr    <= '0;
      evt_a  <= '0;
      evt_b  <= '0;
      sr_out <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        target <= vbr + VEC_OFS;
        spc    <= pc_next;
        ssr    <= sr_in;
        evt_a  <= code;
        evt_b  <= code;
        sr_out <= entry_sr(sr_in);
      end
    end
  end
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         boundary,
  input  logic [31:0]                  sr_in,
  input  logic [31:0]                  pc_next,
  input  logic [31:0]                  vbr,
  input  logic                         dbg_req,
  input  logic                         ext_req,
  input  logic [3:0]                   ext_lvl,
  input  logic [11:0]                  ext_code,
  input  logic                         aux_req,
  input  logic [3:0]                   aux_lvl,
  input  logic [11:0]                  aux_code,
  input  logic [NUM_PERIPH-1:0]        per_req,
  input  logic [4*NUM_PERIPH-1:0]      per_lvl,
  input  logic [12*NUM_PERIPH-1:0]     per_code,
  output logic                         take,
  output logic [31:0]                  target,
  output logic [31:0]                  spc,
  output logic [31:0]                  ssr,
  output logic [11:0]                  evt_a,
  output logic [11:0]                  evt_b,
  output logic [31:0]                  sr_out
);
  localparam int NFIX = 3;
  localparam int NSRC = NFIX + NUM_PERIPH;

  irq_cand_t raw  [NSRC];
  irq_cand_t elig [NSRC];
  irq_cand_t win;

  // Source order doubles as the tie-break order.
  always_comb begin
    raw[0] = '{vld: dbg_req, lvl: DBG_LVL, code: DBG_CODE};
    raw[1] = '{vld: ext_req, lvl: ext_lvl, code: ext_code};
    raw[2] = '{vld: aux_req, lvl: aux_lvl, code: aux_code};
  end

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    always_comb begin
      raw[NFIX+p].vld  = per_req[p];
      raw[NFIX+p].lvl  = per_lvl[LVL_W*p +: LVL_W];
      raw[NFIX+p].code = per_code[CODE_W*p +: CODE_W];
    end
  end

  irq_eligible #(.NSRC(NSRC)) u_elig (
    .raw     (raw),
    .mask    (sr_in[MASK_LO +: LVL_W]),
    .blocked (sr_in[SR_BL]),
    .elig    (elig)
  );

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .elig (elig),
    .win  (win)
  );

  irq_entry_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (boundary && win.vld),
    .code    (win.code),
    .sr_in   (sr_in),
    .pc_next (pc_next),
    .vbr     (vbr),
    .take    (take),
    .target  (target),
    .spc     (spc),
    .ssr     (ssr),
    .evt_a   (evt_a),
    .evt_b   (evt_b),
    .sr_out  (sr_out)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic [31:0] sr_in,
  input logic [31:0] pc_next,
  input logic [31:0] vbr,
  input logic        take,
  input logic [31:0] target,
  input logic [31:0] spc,
  input logic [31:0] ssr,
  input logic [11:0] evt_a,
  input logic [11:0] evt_b,
  input logic [31:0] sr_out
);
  a_r1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(sr_in[28]));
  a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));
  a_r4_spc: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> spc == $past(pc_next));
  a_r5_ssr: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ssr == $past(sr_in));
  a_r6_evt: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> evt_a == evt_b);
  a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (sr_out[30:28] == 3'b111) && (sr_out[7:4] == ssr[7:4]));
  a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> target == $past(vbr) + 32'h600);
  a_r9_dbg_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt_a == 12'h5E0) |-> $past(sr_in[7:4]) != 4'hF);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(spc) && $stable(ssr) && $stable(evt_a) && $stable(sr_out));
endmodule

bind irq_entry irq_entry_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .boundary (boundary),
  .sr_in    (sr_in),
  .pc_next  (pc_next),
  .vbr      (vbr),
  .take     (take),
  .target   (target),
  .spc      (spc),
  .ssr      (ssr),
  .evt_a    (evt_a),
  .evt_b    (evt_b),
  .sr_out   (sr_out)
);

// File: tb/test_irq_entry.sv
module test_irq_entry;
  localparam int NP = 4;

  logic clk = 0, rst_n = 0, boundary = 0;
  logic [31:0] sr_in = 0, pc_next = 0, vbr = 0;
  logic dbg_req = 0, ext_req = 0, aux_req = 0;
  logic [3:0] ext_lvl = 0, aux_lvl = 0;
  logic [11:0] ext_code = 12'h200, aux_code = 12'h700;
  logic [NP-1:0] per_req = 0;
  logic [4*NP-1:0] per_lvl = 0;
  logic [12*NP-1:0] per_code;
  logic take;
  logic [31:0] target, spc, ssr, sr_out;
  logic [11:0] evt_a, evt_b;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_entry #(.NUM_PERIPH(NP)) i_irq_entry (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .sr_in(sr_in),
    .pc_next(pc_next), .vbr(vbr), .dbg_req(dbg_req),
    .ext_req(ext_req), .ext_lvl(ext_lvl), .ext_code(ext_code),
    .aux_req(aux_req), .aux_lvl(aux_lvl), .aux_code(aux_code),
    .per_req(per_req), .per_lvl(per_lvl), .per_code(per_code),
    .take(take), .target(target), .spc(spc), .ssr(ssr),
    .evt_a(evt_a), .evt_b(evt_b), .sr_out(sr_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_sr(input logic bl, input logic [3:0] m);
    logic [31:0] s;
    s = 32'h0000_0301;
    s[28] = bl;
    s[7:4] = m;
    return s;
  endfunction

  task automatic clear_reqs();
    dbg_req = 0; ext_req = 0; aux_req = 0; per_req = '0;
    ext_lvl = 0; aux_lvl = 0; per_lvl = '0;
  endtask

  // Raise boundary for one cycle; return just after the edge that registers it.
  task automatic pulse_boundary();
    boundary = 1;
    @(posedge clk); #1;
    boundary = 0;
  endtask

  task automatic expect_take(input string req, input logic [11:0] code);
    logic [31:0] s0, p0, v0;
    s0 = sr_in; p0 = pc_next; v0 = vbr;
    pulse_boundary();
    chk({req, " take"}, {31'b0, take}, 32'd1);
    chk({req, " evt_a"}, {20'b0, evt_a}, {20'b0, code});
    chk({req, " evt_b"}, {20'b0, evt_b}, {20'b0, code});
    chk("R4 spc", spc, p0);
    chk("R5 ssr", ssr, s0);
    chk("R7 sr_out", sr_out, s0 | 32'h7000_0000);
    chk("R8 target", target, v0 + 32'h600);
    @(posedge clk); #1;
    chk("R3 single pulse", {31'b0, take}, 32'd0);
  endtask

  task automatic expect_none(input string req);
    logic [31:0] spc0;
    spc0 = spc;
    pulse_boundary();
    chk({req, " no take"}, {31'b0, take}, 32'd0);
    chk("R11 spc hold", spc, spc0);
  endtask

  task automatic t_reset();
    chk("R3 reset take", {31'b0, take}, 32'd0);
    chk("R11 reset spc", spc, 32'd0);
    chk("R11 reset evt", {20'b0, evt_a}, 32'd0);
  endtask

  task automatic t_basic();
    clear_reqs();
    sr_in = mk_sr(0, 4'd3); pc_next = 32'h1000_0040; vbr = 32'h8000_0000;
    ext_req = 1; ext_lvl = 4'd5;
    expect_take("R6 ext", 12'h200);
    sr_in = mk_sr(0, 4'd2); pc_next = 32'h2222_0010; vbr = 32'h0000_fa00;
    clear_reqs(); aux_req = 1; aux_lvl = 4'd9;
    expect_take("R6 aux", 12'h700);
  endtask

  task automatic t_block();
    clear_reqs();
    sr_in = mk_sr(1, 4'd0); pc_next = 32'h3333_0000;
    dbg_req = 1; ext_req = 1; ext_lvl = 4'd15;
    expect_none("R1 blocked");
  endtask

  task automatic t_mask();
    clear_reqs();
    sr_in = mk_sr(0, 4'd6); pc_next = 32'h4444_0000;
    per_req[1] = 1; per_lvl[7:4] = 4'd6;
    expect_none("R2 equal level");
    per_lvl[7:4] = 4'd7;
    expect_take("R2 one above", 12'h420);
    // level falls back to the mask before the next boundary
    pc_next = 32'h4444_0100;
    per_lvl[7:4] = 4'd6;
    expect_none("R2 level dropped");
  endtask

  task automatic t_boundary();
    clear_reqs();
    sr_in = mk_sr(0, 4'd0); pc_next = 32'h5555_0000;
    ext_req = 1; ext_lvl = 4'd4;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R3 no boundary", {31'b0, take}, 32'd0);
    end
    expect_take("R3 at boundary", 12'h200);
  endtask

  task automatic t_debug();
    clear_reqs();
    sr_in = mk_sr(0, 4'd14); pc_next = 32'h6666_0000;
    dbg_req = 1;
    expect_take("R9 dbg mask14", 12'h5E0);
    sr_in = mk_sr(0, 4'd15); pc_next = 32'h6666_0100;
    expect_none("R9 dbg mask15");
  endtask

  task automatic t_priority();
    clear_reqs();
    sr_in = mk_sr(0, 4'd0); pc_next = 32'h7777_0000;
    ext_req = 1; ext_lvl = 4'd6; per_req[2] = 1; per_lvl[11:8] = 4'd9;
    expect_take("R10 highest level", 12'h440);
    clear_reqs();
    ext_req = 1; ext_lvl = 4'd7; aux_req = 1; aux_lvl = 4'd7;
    per_req[0] = 1; per_lvl[3:0] = 4'd7;
    expect_take("R10 tie ext first", 12'h200);
    clear_reqs();
    aux_req = 1; aux_lvl = 4'd3; per_req = 4'b1001; per_lvl = {4'd3, 8'd0, 4'd3};
    expect_take("R10 tie aux first", 12'h700);
    clear_reqs();
    per_req = 4'b1010; per_lvl = {4'd8, 4'd0, 4'd8, 4'd0};
    expect_take("R10 tie per index", 12'h420);
    clear_reqs();
    dbg_req = 1; ext_req = 1; ext_lvl = 4'd15; per_req[3] = 1; per_lvl[15:12] = 4'd15;
    expect_take("R10 R9 dbg over 15", 12'h5E0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) per_code[12*i +: 12] = 12'h400 + 12'(32 * i);
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_block();
    t_mask();
    t_boundary();
    t_debug();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule